// File: doc/BRIEF.md
# Lane-Masked Single-Port RAM with Selectable Read-During-Write Result

This block is a synchronous single-port memory. One address bus serves both reads and writes. On a clock edge where the port is enabled, the word at the address is captured into a read data register. If the write strobe is also high on that edge, the same word is updated. The update covers the whole word, or only the byte lanes picked by a per-lane write mask.

Because there is only one address, every enabled write is also a read of the same word. A build-time parameter chooses what the read register returns in that case:
- the word as it stood before the write;
- the word as it stands after the write, with the masked lanes merged in;
- an unspecified value, which lets the implementation choose the cheapest path.

The storage array has no reset. Only the read data register is cleared by reset. Word count and word width are parameters, and the width is a whole number of 8-bit lanes.

Top module: `lane_spram`

## Requirements
- R1: Storage changes only on a rising clock edge where `en` and `we` are both 1; a write strobe with `en` low, or data presented with `we` low, leaves every word unchanged.
- R2: On each rising edge with `en` = 1 and `we` = 0, `rdata` takes the word stored at `addr`, visible from that edge onward (one cycle of latency).
- R3: On a rising edge with `en` = 0, `rdata` keeps its previous value.
- R4: Mask bit i governs data bits [8i+7:8i]. A write updates exactly the lanes whose mask bit is 1; the other lanes keep their contents. When `USE_MASK` is 0 the mask is ignored and every lane is written.
- R5: With `RDW_MODE` = `RDW_OLD`, a write cycle loads `rdata` with the full word as it stood before that write.
- R6: With `RDW_MODE` = `RDW_NEW`, a write cycle loads `rdata` with the updated word: the new data in masked lanes and the old data in the other lanes.
- R7: With `RDW_MODE` = `RDW_ANY`, the value `rdata` takes on a write cycle is unspecified. The write itself still lands exactly as R4 states, so a later read returns it.
- R8: While `rst_n` is 0, `rdata` is cleared to zero on each clock edge. The storage array is not reset.
- R9: The address is `$clog2(WORDS)` bits wide (at least 1). Address 0 and address `WORDS-1` select distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read data register |
| en | input | 1 | Port enable; gates both read capture and write |
| we | input | 1 | Write strobe, effective only with `en` |
| lane_mask | input | WIDTH/8 | Per-byte-lane write select; bit i covers data bits [8i+7:8i] |
| addr | input | AW | Word address shared by read and write |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |

## Verification
The bench drives three instances with the same stimulus, one per collision mode.

It targets the following corner cases:
- **Partial-mask collision in new-data mode.** A design that returned raw write data instead of the merged word would show new bytes in lanes that were never written.
- **Strobe with `en` low.** A design that let `we` alone fire the write would corrupt a word that a later read then exposes.
- **Cycles with `en` low.** A design that tracked `addr` on those cycles would change `rdata`.
- **Zero-mask and alternating-lane writes.** These catch a lane decode that is swapped or inverted.
- **The first and last addresses.** These catch a truncated address.
- **Storage after a collision in don't-care mode.** The collision cycle itself is not compared, but the next read must show the write landed correctly.

// File: rtl/spram_pkg.sv
package spram_pkg;

  // Result loaded into the read register when a write hits the port.
  typedef enum logic [1:0] {
    RDW_OLD = 2'd0,  // word before the write
    RDW_NEW = 2'd1,  // word after the write (lane merge)
    RDW_ANY = 2'd2   // unspecified; implementation picks cheapest path
  } rdw_mode_e;

  localparam int LANE_BITS = 8;

  // Address width for a given word count, never below one bit.
  function automatic int addr_bits(input int words);
    return (words <= 2) ? 1 : $clog2(words);
  endfunction

endpackage

// File: rtl/spram_lane_decode.sv
module spram_lane_decode #(
  parameter int LANES    = 4,
  parameter bit USE_MASK = 1'b1
) (
  input  logic             wr_fire,
  input  logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] lane_we
);

  generate
    if (USE_MASK) begin : g_masked
      assign lane_we = {LANES{wr_fire}} & lane_mask;
    end else begin : g_full
      logic unused_mask;
      assign unused_mask = ^lane_mask;
      assign lane_we     = {LANES{wr_fire}};
    end
  endgenerate

endmodule

// File: rtl/spram_lane_bank.sv
module spram_lane_bank #(
  parameter int WORDS = 64,
  parameter int AW    = 6,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wr_lane,
  output logic [LW-1:0] old_lane
);

  // Storage carries no reset so it maps onto plain memory cells.
  logic [LW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_lane;
  end

  assign old_lane = cells[addr];

endmodule

// File: rtl/spram_read_port.sv
module spram_read_port
  import spram_pkg::*;
#(
  parameter int        WIDTH = 32,
  parameter int        LANES = 4,
  parameter rdw_mode_e MODE  = RDW_OLD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic             wr_fire,
  input  logic [LANES-1:0] lane_we,
  input  logic [WIDTH-1:0] old_word,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  // Combine old and new words lane by lane.
  function automatic logic [WIDTH-1:0] blend(
    input logic [WIDTH-1:0] prev,
    input logic [WIDTH-1:0] next,
    input logic [LANES-1:0] sel
  );
    logic [WIDTH-1:0] out;
    for (int l = 0; l < LANES; l++) begin
      out[l*LANE_BITS +: LANE_BITS] = sel[l] ? next[l*LANE_BITS +: LANE_BITS]
                                             : prev[l*LANE_BITS +: LANE_BITS];
    end
    return out;
  endfunction

  logic [WIDTH-1:0] load_word;

  generate
    if (MODE == RDW_NEW) begin : g_new
      assign load_word = wr_fire ? blend(old_word, wdata, lane_we) : old_word;
    end else begin : g_old
      // Old-data and don't-care both take the array output directly.
      logic unused_wr;
      assign unused_wr = ^{wr_fire, lane_we, wdata};
      assign load_word = old_word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_fire) rdata <= load_word;
  end

endmodule

// File: rtl/lane_spram.sv
module lane_spram
  import spram_pkg::*;
#(
  parameter int        WORDS    = 64,
  parameter int        WIDTH    = 32,
  parameter bit        USE_MASK = 1'b1,
  parameter rdw_mode_e RDW_MODE = RDW_OLD,
  parameter int        AW       = addr_bits(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     we,
  input  logic [WIDTH/8-1:0]       lane_mask,
  input  logic [AW-1:0]            addr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);

  localparam int LANES = WIDTH / LANE_BITS;

  // Named internal events for the checker.
  logic             wr_fire;
  logic             rd_fire;
  logic [LANES-1:0] lane_we;
  logic [WIDTH-1:0] old_word;

  assign wr_fire = en & we;
  assign rd_fire = en;

  spram_lane_decode #(
    .LANES    (LANES),
    .USE_MASK (USE_MASK)
  ) u_decode (
    .wr_fire   (wr_fire),
    .lane_mask (lane_mask),
    .lane_we   (lane_we)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      spram_lane_bank #(
        .WORDS (WORDS),
        .AW    (AW),
        .LW    (LANE_BITS)
      ) u_bank (
        .clk      (clk),
        .wr_en    (lane_we[l]),
        .addr     (addr),
        .wr_lane  (wdata[l*LANE_BITS +: LANE_BITS]),
        .old_lane (old_word[l*LANE_BITS +: LANE_BITS])
      );
    end
  endgenerate

  spram_read_port #(
    .WIDTH (WIDTH),
    .LANES (LANES),
    .MODE  (RDW_MODE)
  ) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .lane_we  (lane_we),
    .old_word (old_word),
    .wdata    (wdata),
    .rdata    (rdata)
  );

endmodule

// File: rtl/spram_checker.sv
module spram_checker
  import spram_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter int        LANES    = 4,
  parameter int        AW       = 6,
  parameter bit        USE_MASK = 1'b1,
  parameter rdw_mode_e MODE     = RDW_OLD
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             we,
  input logic [LANES-1:0] lane_mask,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] old_word
);

  // R1: without a write fire, the word seen at a held address is unchanged.
  p_no_stray_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && we) |=> (addr != $past(addr)) || $isunknown($past(old_word))
                    || (old_word == $past(old_word)));

  // R2: a plain read returns the array word at the address.
  p_read_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we) |=> rdata == $past(old_word));

  // R3: disabled port holds read data.
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  // R4: an all-zero mask leaves the addressed word alone.
  p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_MASK && en && we && lane_mask == '0) |=>
      (addr != $past(addr)) || $isunknown($past(old_word))
      || (old_word == $past(old_word)));

  // R5: old-data mode returns the pre-write word.
  p_old_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == RDW_OLD && en && we) |=> rdata == $past(old_word));

  // R6: new-data mode with every lane written returns the write data.
  p_new_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == RDW_NEW && en && we && (!USE_MASK || (&lane_mask))) |=>
      rdata == $past(wdata));

endmodule

bind lane_spram spram_checker #(
  .WIDTH    (WIDTH),
  .LANES    (LANES),
  .AW       (AW),
  .USE_MASK (USE_MASK),
  .MODE     (RDW_MODE)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .we        (we),
  .lane_mask (lane_mask),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .old_word  (old_word)
);

// File: tb/test_lane_spram.sv
`timescale 1ns/1ps
module test_lane_spram;
  import spram_pkg::*;

  localparam int WORDS = 64;
  localparam int WIDTH = 32;
  localparam int LANES = WIDTH / 8;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic             rst_n, en, we;
  logic [LANES-1:0] mask;
  logic [AW-1:0]    addr;
  logic [WIDTH-1:0] wdata;
  wire  [WIDTH-1:0] rd_old, rd_new, rd_any;

  lane_spram #(.WORDS(WORDS), .WIDTH(WIDTH), .RDW_MODE(RDW_OLD)) i_lane_spram (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .lane_mask(mask),
    .addr(addr), .wdata(wdata), .rdata(rd_old));
  lane_spram #(.WORDS(WORDS), .WIDTH(WIDTH), .RDW_MODE(RDW_NEW)) i_lane_spram_new (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .lane_mask(mask),
    .addr(addr), .wdata(wdata), .rdata(rd_new));
  lane_spram #(.WORDS(WORDS), .WIDTH(WIDTH), .RDW_MODE(RDW_ANY)) i_lane_spram_any (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .lane_mask(mask),
    .addr(addr), .wdata(wdata), .rdata(rd_any));

  int n_cmp = 0;
  int n_bad = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R8";

  // Behavioural reference: sparse word store plus expected read values.
  logic [WIDTH-1:0] ref_mem [int];
  logic [WIDTH-1:0] e_old, e_new, e_any;
  bit               v_old, v_new, v_any;
  string            t_old, t_new, t_any;

  always @(posedge clk) begin : model
    bit               known;
    logic [WIDTH-1:0] prev, upd;
    if (!rst_n) begin
      e_old = '0; e_new = '0; e_any = '0;
      v_old = 1;  v_new = 1;  v_any = 1;
      t_old = "R8"; t_new = "R8"; t_any = "R8";
    end else if (en) begin
      known = ref_mem.exists(int'(addr));
      prev  = known ? ref_mem[int'(addr)] : 'x;
      upd   = prev;
      for (int b = 0; b < WIDTH; b++) if (mask[b / 8]) upd[b] = wdata[b];
      if (we) begin
        e_old = prev; v_old = known;              t_old = "R5";
        e_new = upd;  v_new = known || (&mask);   t_new = "R6";
        v_any = 0;                                t_any = "R7";
        if (known || (&mask)) ref_mem[int'(addr)] = upd;
      end else begin
        e_old = prev; v_old = known; t_old = cur_tag;
        e_new = prev; v_new = known; t_new = cur_tag;
        e_any = prev; v_any = known; t_any = cur_tag;
      end
    end else begin
      t_old = cur_tag; t_new = cur_tag;
      if (v_any) t_any = cur_tag;
    end
  end

  task automatic cmp(input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp,
                     input bit valid, input string tag, input string inst);
    if (valid) begin
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, inst, $time, act, exp);
      end
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      cmp(rd_old, e_old, v_old, t_old, "old");
      cmp(rd_new, e_new, v_new, t_new, "new");
      cmp(rd_any, e_any, v_any, t_any, "any");
    end
  end

  task automatic op(input bit e, input bit w, input logic [LANES-1:0] m,
                    input int a, input logic [WIDTH-1:0] d, input string tg);
    en = e; we = w; mask = m; addr = AW'(a); wdata = d; cur_tag = tg;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; en = 0; we = 0; mask = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    checking = 1;                                   // R8 reset value
    op(1, 0, '0, 3, 32'h0, "R8");                   // enable during reset still zero
    rst_n = 1;
    op(0, 0, '0, 0, 32'h0, "R8");                   // R8 value held after release
    for (int a = 0; a < WORDS; a++)
      op(1, 1, '1, a, 32'h1000_0000 + a * 32'h0101_0103, "R9");
    op(1, 0, '0, 0, 32'h0, "R9");                   // R9 first word
    op(1, 0, '0, WORDS - 1, 32'h0, "R9");           // R9 last word
    op(0, 1, '1, 5, 32'hDEAD_0005, "R1");           // R1 strobe without enable
    op(1, 0, '1, 5, 32'hBEEF_0005, "R1");           // R1 data without strobe
    op(1, 0, '0, 5, 32'h0, "R1");
    op(1, 0, '0, 10, 32'h0, "R2");
    for (int k = 0; k < 3; k++) op(0, 0, '1, 11 + k, 32'hFFFF_FFFF, "R3");
    op(1, 1, 4'b0101, 7, 32'hA1B2_C3D4, "R4");       // R4 alternate lanes
    op(1, 0, '0, 7, 32'h0, "R4");
    op(1, 1, 4'b0000, 8, 32'h5555_5555, "R4");       // R4 empty mask
    op(1, 0, '0, 8, 32'h0, "R4");
    op(1, 1, 4'b0011, 9, 32'h1357_9BDF, "R6");       // R6 partial merge
    op(1, 0, '0, 9, 32'h0, "R7");                   // R7 storage after collision
    op(1, 1, 4'b1000, 12, 32'hCAFE_F00D, "R5");
    op(1, 0, '0, 12, 32'h0, "R7");
    for (int k = 0; k < 3000; k++) begin : rnd
      int unsigned r;
      r = $urandom;
      op(r[0] | r[1], r[2], LANES'(r[7:4]), int'(r[13:8]) % WORDS, $urandom, "R2");
    end
    op(0, 0, '0, 0, 32'h0, "R3");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule